// File: doc/BRIEF.md
# Bus/Device/Function Enumeration Scanner

This block walks a configurable range of buses, visiting each of the 32 device slots on every bus and up to 8 functions per device. For each slot it issues one configuration read of the identity dword at register offset 0x00. It then decides from the response whether the function exists. Functions that exist are sent out on a valid/ready stream as discovery records, and a running count of them is kept. A function is absent when the response carries an abort, or when the low 16 bits of the returned dword (the vendor identity) are all ones. Function 0 is mandatory for a device. When it is missing, the scanner moves straight to the next device and skips functions 1 to 7.

The scan runs one read at a time. The next request is raised only after the previous response has been taken and, for a present function, after its record has left the output stream. Both the request port and the output stream follow valid/ready rules. A raised valid stays high, and its payload does not change, until the matching ready is seen high at a clock edge. Holding `out_ready` low therefore stalls the whole scan without losing a record. The response port has no ready. It is sampled only while a request is outstanding. `start`, `busy`, `done` and the count are plain level signals.

Top module: `enum_scanner`

## Requirements
- R1: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_bus`, `req_dev` and `req_fn` hold their values. `req_reg` is 0x00 whenever `req_valid` is high.
- R2: Requests step with the function number innermost, then the device number 0..31, then the bus number, starting at `first_bus` device 0 function 0. A new request is raised only after the previous one has been answered on `rsp_valid`.
- R3: A response with `rsp_abort` high, or with `rsp_data[15:0]` equal to 0xFFFF, produces no output record.
- R4: When function 0 of a device is absent, functions 1 to 7 of that device are not requested, and the next request is function 0 of the following device.
- R5: A present function yields one output record: `out_bus`, `out_dev`, `out_fn`, `out_did` = `rsp_data[31:16]` and `out_vid` = `rsp_data[15:0]`. The record is held stable while `out_ready` is low, and no new request is raised until it is accepted.
- R6: `found_count` rises by one for each record accepted on the output stream. It is cleared when a scan is launched.
- R7: After the last function handled on device 31 of a bus at or above `last_bus`, `done` goes high, `busy` goes low and no further request is raised. If `first_bus` exceeds `last_bus`, only `first_bus` is scanned.
- R8: `start` is ignored while `busy` is high. A `start` while idle clears `done` and the count, latches `first_bus` and `last_bus`, and begins a fresh scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a scan when idle |
| first_bus | input | 8 | First bus of the range |
| last_bus | input | 8 | Last bus of the range |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, held until the next launch |
| found_count | output | 17 | Records accepted in this scan |
| req_valid | output | 1 | Configuration read request valid |
| req_ready | input | 1 | Request accepted |
| req_bus | output | 8 | Requested bus |
| req_dev | output | 5 | Requested device |
| req_fn | output | 3 | Requested function |
| req_reg | output | 8 | Register offset, always 0x00 |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read data: device identity high, vendor identity low |
| rsp_abort | input | 1 | Read ended in an abort |
| out_valid | output | 1 | Discovery record valid |
| out_ready | input | 1 | Discovery record accepted |
| out_bus | output | 8 | Record bus |
| out_dev | output | 5 | Record device |
| out_fn | output | 3 | Record function |
| out_did | output | 16 | Record device identity |
| out_vid | output | 16 | Record vendor identity |

## Verification
The responder models a bus population that mixes several patterns. Some devices are multi-function with gaps between functions, one has only function 0, and one has all eight functions. Absence is signalled by abort on even device slots and by an all-ones vendor field on odd ones, which separates the two absence checks. One device lacks function 0 but would answer on function 1, so a scanner that fails to skip shows up as an unexpected request. Request and output stalls of varying length exercise the hold rules. Scans over two buses, a reversed range, a start pulse mid-scan and a relaunch after completion separate the bus ordering, the range ending, the ignored start and the clearing of the count.

// File: rtl/enum_pkg.sv
package enum_pkg;
  localparam int ID_W   = 16;
  localparam int DATA_W = 32;
  localparam int REG_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EMIT
  } scan_state_t;
endpackage

// File: rtl/enum_cursor.sv
module enum_cursor #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] load_bus,
  input  logic [BUS_W-1:0] end_bus,
  input  logic             step,
  input  logic             skip,
  output logic [BUS_W-1:0] bus,
  output logic [DEV_W-1:0] dev,
  output logic [FN_W-1:0]  fn,
  output logic             final_probe
);
  localparam logic [DEV_W-1:0] DEV_LAST = '1;
  localparam logic [FN_W-1:0]  FN_LAST  = '1;

  logic dev_wrap;
  assign dev_wrap    = skip || (fn == FN_LAST);
  assign final_probe = dev_wrap && (dev == DEV_LAST) && (bus >= end_bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus <= '0;
      dev <= '0;
      fn  <= '0;
    end else if (load) begin
      bus <= load_bus;
      dev <= '0;
      fn  <= '0;
    end else if (step) begin
      if (dev_wrap) begin
        fn <= '0;
        if (dev == DEV_LAST) begin
          dev <= '0;
          bus <= bus + 1'b1;
        end else begin
          dev <= dev + 1'b1;
        end
      end else begin
        fn <= fn + 1'b1;
      end
    end
  end
endmodule

// File: rtl/enum_classify.sv
module enum_classify
  import enum_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic              abort,
  output logic              present,
  output logic [ID_W-1:0]   vid,
  output logic [ID_W-1:0]   did
);
  assign vid     = data[ID_W-1:0];
  assign did     = data[DATA_W-1:ID_W];
  assign present = !abort && (vid != {ID_W{1'b1}});
endmodule

// File: rtl/enum_scanner.sv
module enum_scanner
  import enum_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  localparam int CNT_W = BUS_W + DEV_W + FN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUS_W-1:0]  first_bus,
  input  logic [BUS_W-1:0]  last_bus,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  found_count,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BUS_W-1:0]  req_bus,
  output logic [DEV_W-1:0]  req_dev,
  output logic [FN_W-1:0]   req_fn,
  output logic [REG_W-1:0]  req_reg,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_abort,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUS_W-1:0]  out_bus,
  output logic [DEV_W-1:0]  out_dev,
  output logic [FN_W-1:0]   out_fn,
  output logic [ID_W-1:0]   out_did,
  output logic [ID_W-1:0]   out_vid
);
  scan_state_t state_q, state_d;
  logic [BUS_W-1:0] end_bus_q;
  logic [CNT_W-1:0] count_q;
  logic [ID_W-1:0]  vid_q, did_q;
  logic             done_q;

  logic [BUS_W-1:0] cur_bus;
  logic [DEV_W-1:0] cur_dev;
  logic [FN_W-1:0]  cur_fn;
  logic             final_probe;
  logic             present;
  logic [ID_W-1:0]  rsp_vid, rsp_did;

  logic launch, rsp_take, emit_take, step, skip;

  assign launch    = start && (state_q == ST_IDLE);
  assign rsp_take  = (state_q == ST_WAIT) && rsp_valid;
  assign emit_take = (state_q == ST_EMIT) && out_ready;
  assign step      = (rsp_take && !present) || emit_take;
  assign skip      = rsp_take && !present && (cur_fn == '0);

  enum_cursor #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W)) u_cursor (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (launch),
    .load_bus    (first_bus),
    .end_bus     (end_bus_q),
    .step        (step),
    .skip        (skip),
    .bus         (cur_bus),
    .dev         (cur_dev),
    .fn          (cur_fn),
    .final_probe (final_probe)
  );

  enum_classify u_classify (
    .data    (rsp_data),
    .abort   (rsp_abort),
    .present (present),
    .vid     (rsp_vid),
    .did     (rsp_did)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch) state_d = ST_REQ;
      ST_REQ:  if (req_ready) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) begin
        if (present)          state_d = ST_EMIT;
        else if (final_probe) state_d = ST_IDLE;
        else                  state_d = ST_REQ;
      end
      ST_EMIT: if (out_ready) state_d = final_probe ? ST_IDLE : ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      end_bus_q <= '0;
      count_q   <= '0;
      done_q    <= 1'b0;
      vid_q     <= '0;
      did_q     <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        end_bus_q <= last_bus;
        count_q   <= '0;
        done_q    <= 1'b0;
      end else begin
        if (emit_take) count_q <= count_q + 1'b1;
        if (step && final_probe) done_q <= 1'b1;
      end
      if (rsp_take && present) begin
        vid_q <= rsp_vid;
        did_q <= rsp_did;
      end
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign found_count = count_q;

  assign req_valid = (state_q == ST_REQ);
  assign req_bus   = cur_bus;
  assign req_dev   = cur_dev;
  assign req_fn    = cur_fn;
  assign req_reg   = '0;

  assign out_valid = (state_q == ST_EMIT);
  assign out_bus   = cur_bus;
  assign out_dev   = cur_dev;
  assign out_fn    = cur_fn;
  assign out_did   = did_q;
  assign out_vid   = vid_q;
endmodule

// File: rtl/enum_scanner_chk.sv
module enum_scanner_chk
  import enum_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int CNT_W = BUS_W + DEV_W + FN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [CNT_W-1:0] found_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic [BUS_W-1:0] req_bus,
  input logic [DEV_W-1:0] req_dev,
  input logic [FN_W-1:0]  req_fn,
  input logic [REG_W-1:0] req_reg,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BUS_W-1:0] out_bus,
  input logic [DEV_W-1:0] out_dev,
  input logic [FN_W-1:0]  out_fn,
  input logic [ID_W-1:0]  out_did,
  input logic [ID_W-1:0]  out_vid
);
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_bus) && $stable(req_dev) && $stable(req_fn));

  assert_req_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_reg == '0);

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !out_valid);

  assert_absent_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_vid != {ID_W{1'b1}});

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bus) && $stable(out_dev) &&
      $stable(out_fn) && $stable(out_did) && $stable(out_vid));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found_count != $past(found_count) |-> $past(out_valid && out_ready) || $past(start));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && !out_valid);
endmodule

bind enum_scanner enum_scanner_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .found_count(found_count),
  .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus), .req_dev(req_dev),
  .req_fn(req_fn), .req_reg(req_reg), .out_valid(out_valid), .out_ready(out_ready),
  .out_bus(out_bus), .out_dev(out_dev), .out_fn(out_fn), .out_did(out_did),
  .out_vid(out_vid)
);

// File: tb/sim_enum_scanner.sv
module sim_enum_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  first_bus = '0, last_bus = '0;
  logic        busy, done;
  logic [16:0] found_count;
  logic        req_valid, req_ready;
  logic [7:0]  req_bus, req_reg;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic        rsp_valid, rsp_abort;
  logic [31:0] rsp_data;
  logic        out_valid, out_ready;
  logic [7:0]  out_bus;
  logic [4:0]  out_dev;
  logic [2:0]  out_fn;
  logic [15:0] out_did, out_vid;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit out_stall = 1'b0;
  logic [15:0] exp_req[$];
  logic [47:0] exp_out[$];
  int exp_count;

  always #10 clk = ~clk;

  enum_scanner u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .first_bus(first_bus), .last_bus(last_bus),
    .busy(busy), .done(done), .found_count(found_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus), .req_dev(req_dev),
    .req_fn(req_fn), .req_reg(req_reg), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_abort(rsp_abort), .out_valid(out_valid), .out_ready(out_ready),
    .out_bus(out_bus), .out_dev(out_dev), .out_fn(out_fn), .out_did(out_did),
    .out_vid(out_vid)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  function automatic bit fn_present(int b, int d, int f);
    case (d)
      0: return (f == 0) || (f == 1) || (f == 3);
      2: return f == 0;
      5: return f == 1;
      7: return 1'b1;
      9: return (b == 2) && (f == 0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] vid_of(int b, int d, int f);
    return {b[7:0], d[4:0], f[2:0]};
  endfunction

  function automatic logic [15:0] did_of(int b, int d, int f);
    return 16'hC000 + 16'(b * 37 + d * 5 + f);
  endfunction

  // Driver side: expected request and record streams for a range
  task automatic plan_scan(int fb, int lb);
    int b = fb;
    exp_req.delete();
    exp_out.delete();
    exp_count = 0;
    forever begin
      for (int d = 0; d < 32; d++) begin
        for (int f = 0; f < 8; f++) begin
          exp_req.push_back({b[7:0], d[4:0], f[2:0]});
          if (fn_present(b, d, f)) begin
            exp_out.push_back({b[7:0], d[4:0], f[2:0], did_of(b, d, f), vid_of(b, d, f)});
            exp_count++;
          end else if (f == 0) begin
            break;
          end
        end
      end
      if (b >= lb) break;
      b++;
    end
  endtask

  // Responder: checks each request and answers it
  initial begin
    int stall_n = 0;
    int lat = 0;
    logic [15:0] e;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_abort = 1'b0;
    rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        chk(req_reg == 8'h00, "R1 register offset", 64'(req_reg), 64'h0);
        if (exp_req.size() == 0) begin
          chk(1'b0, "R4 unexpected request", 64'({req_bus, req_dev, req_fn}), 64'h0);
          e = {req_bus, req_dev, req_fn};
        end else begin
          e = exp_req.pop_front();
          chk({req_bus, req_dev, req_fn} == e, "R2 request order",
              64'({req_bus, req_dev, req_fn}), 64'(e));
        end
        repeat (stall_n) @(negedge clk);
        stall_n = (stall_n + 1) % 3;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 2;
        if (fn_present(e[15:8], e[7:3], e[2:0])) begin
          rsp_abort = 1'b0;
          rsp_data  = {did_of(e[15:8], e[7:3], e[2:0]), vid_of(e[15:8], e[7:3], e[2:0])};
        end else if (e[3]) begin
          rsp_abort = 1'b0;
          rsp_data  = 32'h1234_FFFF;
        end else begin
          rsp_abort = 1'b1;
          rsp_data  = 32'h0000_0000;
        end
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_abort = 1'b0;
      end
    end
  end

  // Monitor: pops records as they are accepted
  initial begin
    logic [47:0] e;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = out_stall ? (cyc % 3 == 2) : 1'b1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_out.size() == 0) begin
          chk(1'b0, "R3 unexpected record", 64'({out_bus, out_dev, out_fn, out_did, out_vid}), 64'h0);
        end else begin
          e = exp_out.pop_front();
          chk({out_bus, out_dev, out_fn, out_did, out_vid} == e, "R5 record",
              64'({out_bus, out_dev, out_fn, out_did, out_vid}), 64'(e));
        end
      end
    end
  end

  task automatic launch(int fb, int lb);
    plan_scan(fb, lb);
    first_bus = fb[7:0];
    last_bus  = lb[7:0];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8 done cleared on launch", 64'(done), 64'h0);
    chk(found_count == 0, "R6 count cleared on launch", 64'(found_count), 64'h0);
    chk(busy == 1'b1, "R8 busy after launch", 64'(busy), 64'h1);
  endtask

  task automatic finish_scan(string tag);
    int n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R7 done reached", 64'(done), 64'h1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && req_valid == 1'b0, "R7 quiet after done", 64'({busy, req_valid}), 64'h0);
    chk(exp_req.size() == 0, "R4 all expected requests seen", 64'(exp_req.size()), 64'h0);
    chk(exp_out.size() == 0, "R5 all records delivered", 64'(exp_out.size()), 64'h0);
    chk(found_count == 17'(exp_count), "R6 found count", 64'(found_count), 64'(exp_count));
    $display("scan %s finished, %0d records", tag, exp_count);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 0 && out_valid == 0 && done == 0 && busy == 0 && found_count == 0,
        "R7 reset state", 64'({req_valid, out_valid, done, busy, found_count}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Single bus with output back-pressure
    out_stall = 1'b1;
    launch(3, 3);
    finish_scan("bus3");
    out_stall = 1'b0;

    // Two buses, start pulse mid-scan must be ignored (R8)
    launch(1, 2);
    repeat (40) @(negedge clk);
    first_bus = 8'd9;
    last_bus  = 8'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_bus = 8'd1;
    last_bus  = 8'd2;
    finish_scan("bus1-2");

    // Reversed range: only the first bus (R7)
    launch(6, 4);
    finish_scan("bus6 reversed");

    // Relaunch after completion clears the count (R6, R8)
    out_stall = 1'b1;
    launch(0, 0);
    finish_scan("bus0");

    report();
  end
endmodule